// File: doc/BRIEF.md
# Access Wait-State and Clock Sequencer

This block sets the length of each bus access in master-clock cycles. It works the length out from the 24-bit address (high byte as bank, next byte as page), a fast-ROM enable bit, and a DMA flag. It then runs through that length two master clocks per clock cycle, and keeps a CPU stall (`busy`) asserted until the whole length has been used. A free-running 64-bit master-clock count advances by two on every step. A one-cycle video tick fires whenever a step leaves that count at a multiple of four.

Requests use a valid/ready handshake. `req_ready` is high exactly when the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. At that edge the address, DMA flag and fast-ROM bit are captured, so later changes to them cannot alter an access already in progress. While `busy` is high, `req_valid` is ignored, and the requester must hold or retry its request. `done` pulses in the cycle after the final step, and a new request may be accepted in that same cycle.

Top module: `access_timing_seq`

## Requirements
- R1: After reset, `mclk_count` is 0, and `busy`, `done` and `video_tick` are 0, with `req_ready` at 1.
- R2: A non-DMA access to banks 0x40 through 0x7F lasts 8 master clocks.
- R3: A non-DMA access to banks 0xC0 through 0xFF lasts 6 master clocks when fast-ROM is 1, and 8 when it is 0.
- R4: In banks 0x00–0x3F and 0x80–0xBF, non-DMA accesses below offset 0x8000 take their length from the page byte: pages 0x40–0x41 take 12; pages 0x20–0x3F and 0x42–0x5F take 6; pages 0x00–0x1F and 0x60–0x7F take 8.
- R5: A non-DMA access to pages 0x80 and up takes 8 in banks 0x00–0x3F. In banks 0x80–0xBF it takes 6 with fast-ROM set and 8 with it clear.
- R6: When the DMA flag is set, an access lasts 4 master clocks at any address and for either fast-ROM value.
- R7: An access of length L holds `busy` for L/2 cycles after acceptance, and each of those cycles adds 2 to `mclk_count`, so the count ends L higher.
- R8: `video_tick` is high for exactly one cycle after each step that leaves `mclk_count` a multiple of 4, and is low otherwise.
- R9: `req_ready` equals the inverse of `busy`. A request presented while busy is ignored. A change to the address, DMA flag or fast-ROM bit after acceptance does not change the running access.
- R10: `done` is high for exactly one cycle, in the cycle after the last step. `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request can be accepted (idle) |
| req_addr | input | 24 | Access address, bank in the top byte |
| req_dma | input | 1 | Access is a DMA transfer |
| fast_rom_en | input | 1 | Fast-ROM speed for upper banks |
| busy | output | 1 | Access in progress, CPU stalled |
| done | output | 1 | One-cycle pulse after the final step |
| mclk_count | output | 64 | Running master-clock count |
| video_tick | output | 1 | One-cycle tick at each multiple of four |

## Verification
The assertions assume that `rst_n` holds for at least one edge. They also assume that every accepted length is one of 4, 6, 8 or 12, so the step count loaded into the sequencer is 2, 3, 4 or 6. The stimulus draws random banks and pages, random DMA flags and random fast-ROM values, and adds directed corners at each boundary of the region table. It drops `req_valid` before the done cycle, except for deliberate requests made while busy. During an access it changes the fast-ROM bit and the address to show that only the values captured at acceptance count.

// File: rtl/acc_timing_pkg.sv
package acc_timing_pkg;
  localparam int STEP_W = 3;
  typedef logic [STEP_W-1:0] steps_t;
  localparam steps_t STEPS_DMA   = 3'd2;
  localparam steps_t STEPS_FAST  = 3'd3;
  localparam steps_t STEPS_SLOW  = 3'd4;
  localparam steps_t STEPS_XSLOW = 3'd6;
endpackage

// File: rtl/acc_region_decode.sv
module acc_region_decode
  import acc_timing_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              dma,
  input  logic              fast,
  output steps_t            steps
);
  localparam int BANK_LSB = ADDR_W - 8;
  localparam int PAGE_LSB = ADDR_W - 16;

  logic [7:0] bank, page;
  steps_t     rom_hi;

  assign bank   = addr[BANK_LSB +: 8];
  assign page   = addr[PAGE_LSB +: 8];
  assign rom_hi = fast ? STEPS_FAST : STEPS_SLOW;

  always_comb begin
    if (dma)                                steps = STEPS_DMA;
    else if (bank >= 8'hC0)                 steps = rom_hi;
    else if (bank >= 8'h40 && bank < 8'h80) steps = STEPS_SLOW;
    else if (page >= 8'h80)                 steps = bank[7] ? rom_hi : STEPS_SLOW;
    else if (page >= 8'h60)                 steps = STEPS_SLOW;
    else if (page >= 8'h42)                 steps = STEPS_FAST;
    else if (page >= 8'h40)                 steps = STEPS_XSLOW;
    else if (page >= 8'h20)                 steps = STEPS_FAST;
    else                                    steps = STEPS_SLOW;
  end
endmodule

// File: rtl/acc_step_seq.sv
module acc_step_seq
  import acc_timing_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  steps_t start_steps,
  output logic   busy,
  output logic   step_en,
  output logic   done
);
  steps_t rem;

  assign step_en = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      rem  <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        rem <= rem - 1'b1;
        if (rem == steps_t'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
        rem  <= start_steps;
      end
    end
  end

  // R7: only legal lengths are ever loaded
  p_legal_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |-> (start_steps == STEPS_DMA || start_steps == STEPS_FAST ||
                        start_steps == STEPS_SLOW || start_steps == STEPS_XSLOW));
  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  p_last_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rem == steps_t'(1) |=> done && !busy);
  // R9: a busy sequencer ignores start and keeps counting down
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rem != steps_t'(1) |=> busy && rem == $past(rem) - 1'b1);
endmodule

// File: rtl/mclk_tick_gen.sv
module mclk_tick_gen #(
  parameter int CNT_W    = 64,
  parameter int STEP     = 2,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);
  localparam int DIV_W = $clog2(TICK_DIV);

  logic [CNT_W-1:0] cnt_nxt;
  assign cnt_nxt = cnt + CNT_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (step_en) begin
        cnt  <= cnt_nxt;
        tick <= (cnt_nxt[DIV_W-1:0] == '0);
      end
    end
  end

  // R7: each step adds exactly STEP
  p_step_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> cnt == $past(cnt) + CNT_W'(STEP));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(cnt));
  // R8: a tick only follows a step landing on a multiple of the divider
  p_tick_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> cnt[DIV_W-1:0] == '0 && $past(step_en));
endmodule

// File: rtl/access_timing_seq.sv
module access_timing_seq
  import acc_timing_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int CNT_W    = 64,
  parameter int STEP     = 2,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic             req_dma,
  input  logic             fast_rom_en,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] mclk_count,
  output logic             video_tick
);
  steps_t len_steps;
  logic   step_en;
  logic   accept;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  acc_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr  (req_addr),
    .dma   (req_dma),
    .fast  (fast_rom_en),
    .steps (len_steps)
  );

  acc_step_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_steps (len_steps),
    .busy        (busy),
    .step_en     (step_en),
    .done        (done)
  );

  mclk_tick_gen #(.CNT_W(CNT_W), .STEP(STEP), .TICK_DIV(TICK_DIV)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .cnt     (mclk_count),
    .tick    (video_tick)
  );

  // R9: acceptance always starts an access
  p_accept_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy);
  // R1/R7: the count never moves while idle
  p_idle_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(mclk_count));
endmodule

// File: tb/tb_access_timing_seq.sv
module tb_access_timing_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_dma = 0;
  logic        fast_rom_en = 0;
  logic        busy, done, video_tick;
  logic [63:0] mclk_count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  access_timing_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_dma(req_dma), .fast_rom_en(fast_rom_en),
    .busy(busy), .done(done), .mclk_count(mclk_count), .video_tick(video_tick)
  );

  function automatic int exp_len(logic [23:0] a, logic dma, logic fast);
    logic [7:0] b = a[23:16];
    logic [7:0] p = a[15:8];
    if (dma) return 4;
    if (b >= 8'hC0) return fast ? 6 : 8;
    if (b >= 8'h40 && b <= 8'h7F) return 8;
    if (p >= 8'h80) return (b >= 8'h80 && fast) ? 6 : 8;
    if (p <= 8'h1F) return 8;
    if (p <= 8'h3F) return 6;
    if (p <= 8'h41) return 12;
    if (p <= 8'h5F) return 6;
    return 8;
  endfunction

  function automatic string req_of(logic [23:0] a, logic dma);
    logic [7:0] b = a[23:16];
    if (dma) return "R6";
    if (b >= 8'hC0) return "R3";
    if (b >= 8'h40 && b <= 8'h7F) return "R2";
    if (a[15]) return "R5";
    return "R4";
  endfunction

  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // One access; if poke is set, a foreign request and fast-ROM flip hit while busy (R9)
  task automatic run_access(logic [23:0] a, logic dma, logic fast, bit poke);
    longint c0, L, cyc, ticks, eticks;
    string rq;
    L  = exp_len(a, dma, fast);
    rq = req_of(a, dma);
    @(negedge clk);
    check(req_ready == 1'b1 && busy == 1'b0, "R9", "ready when idle", req_ready, 1);
    c0 = mclk_count;
    req_addr = a; req_dma = dma; fast_rom_en = fast; req_valid = 1;
    @(negedge clk);
    check(busy == 1'b1 && req_ready == 1'b0, "R9", "busy after accept", busy, 1);
    if (poke) begin
      req_addr = ~a; req_dma = ~dma; fast_rom_en = ~fast; req_valid = 1;
    end else req_valid = 0;
    cyc = 0; ticks = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      req_valid = 0;
      cyc++;
      if (video_tick) ticks++;
      if (done) break;
    end
    eticks = 0;
    for (longint k = 1; k <= L / 2; k++) if (((c0 + 2 * k) % 4) == 0) eticks++;
    check(cyc == L / 2, rq, "busy cycles", cyc, L / 2);
    check(mclk_count == c0 + L, "R7", "count delta", mclk_count - c0, L);
    check(ticks == eticks, "R8", "video ticks", ticks, eticks);
    check(busy == 1'b0, "R10", "idle in done cycle", busy, 0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10", "done one cycle", done, 0);
    check(video_tick == 1'b0, "R8", "no tick when idle", video_tick, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(mclk_count == 0 && !busy && !done && !video_tick && req_ready, "R1",
          "reset state", mclk_count, 0);
    rst_n = 1;
    @(negedge clk);
    check(mclk_count == 0, "R1", "count after reset", mclk_count, 0);
    // directed corners
    run_access(24'h401234, 0, 1, 0);  // R2
    run_access(24'h7FFFFF, 0, 1, 0);  // R2
    run_access(24'hC00000, 0, 1, 0);  // R3
    run_access(24'hFFFFFF, 0, 0, 0);  // R3
    run_access(24'h001F00, 0, 0, 0);  // R4
    run_access(24'h002000, 0, 0, 0);  // R4
    run_access(24'h804000, 0, 1, 0);  // R4
    run_access(24'h3F41FF, 0, 0, 0);  // R4
    run_access(24'h004200, 0, 0, 0);  // R4
    run_access(24'h805FFF, 0, 0, 0);  // R4
    run_access(24'h006000, 0, 1, 0);  // R4
    run_access(24'h3F8000, 0, 1, 0);  // R5
    run_access(24'h808000, 0, 1, 0);  // R5
    run_access(24'hBFFFFF, 0, 0, 0);  // R5
    run_access(24'h414000, 1, 0, 0);  // R6
    run_access(24'h004000, 1, 1, 0);  // R6
    run_access(24'h004100, 0, 0, 1);  // R9 poke while busy
    run_access(24'hC08000, 0, 0, 1);  // R9 fast flip ignored
    run_access(24'h7E0000, 1, 1, 1);  // R9 with DMA
    for (int n = 0; n < 300; n++) begin
      a = $urandom;
      run_access(a, ($urandom % 5) == 0, $urandom % 2, ($urandom % 4) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule